// File: doc/BRIEF.md
# Two's-Complement Array Multiplier

This block multiplies two WIDTH-bit operands and presents the full 2·WIDTH-bit product combinationally. It is a regular array: a matrix of single-gate partial products, followed by one ripple adder row for each multiplier bit above bit zero. Each row folds its partial-product row into the running sum. The lowest bit of each row leaves the array as a product bit. The last row supplies the upper half of the product.

In signed mode the array computes the two's-complement product without widening either operand. Any partial product that pairs exactly one sign bit with a non-sign bit is formed inverted. A constant one is added at column WIDTH, and the carry leaving the final row is inverted to give the top product bit. Setting SIGNED_MODE to 0 turns the same array into an unsigned multiplier. In that mode every partial product is a plain AND, nothing is injected, and the final carry is the top bit.

The block has no clock and no state. It has no streaming handshake either. A caller registers the operands and the product around it as the surrounding pipeline needs.

Top module: `bw_array_mult`

## Requirements
- R1: With SIGNED_MODE=1, `product` equals the exact two's-complement product of `op_a` and `op_b`, both taken as signed WIDTH-bit values, for every operand pair.
- R2: With SIGNED_MODE=1, the most negative operand times itself gives the positive value 2^(2·WIDTH−2). For WIDTH=4, (−8)·(−8) gives 0x40.
- R3: `product` bit 0 always equals `op_a[0]` AND `op_b[0]`, in both modes.
- R4: With SIGNED_MODE=1, when both operands are nonzero, `product` bit 2·WIDTH−1 equals `op_a[WIDTH−1]` XOR `op_b[WIDTH−1]`.
- R5: With SIGNED_MODE=0, `product` equals the exact unsigned product of `op_a` and `op_b` for every operand pair.
- R6: With SIGNED_MODE=0, the all-ones operand times itself gives (2^WIDTH−1)^2. For WIDTH=4 this is 0xE1.
- R7: In either mode, a zero on either operand gives an all-zero `product`.
- R8: With SIGNED_MODE=1, multiplying by −1 (all ones) gives the two's-complement negation of the other operand, taken over 2·WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Multiplicand; signed or unsigned according to SIGNED_MODE |
| op_b | input | WIDTH | Multiplier; signed or unsigned according to SIGNED_MODE |
| product | output | 2*WIDTH | Full-width product of op_a and op_b |

## Verification
The embedded assertions are immediate checks that compare the settled product against an arithmetic model. They assume that both operands carry known 0/1 values and are held steady long enough for the array to settle. The bench meets this by changing operands only on a rising clock edge and reading `product` half a period later. It sweeps every operand pair exhaustively, for a 4-bit signed array, a 4-bit unsigned array and a 6-bit signed array.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

  // True when the partial product of multiplicand bit col and multiplier
  // bit row must be inverted: exactly one of the two is a sign bit.
  function automatic logic pp_is_inverted(input int row, input int col,
                                          input int width, input bit signed_mode);
    logic row_top;
    logic col_top;
    row_top = (row == width - 1);
    col_top = (col == width - 1);
    return signed_mode && (row_top ^ col_top);
  endfunction

endpackage

// File: rtl/bw_half_adder.sv
module bw_half_adder (
  input  logic in_x,
  input  logic in_y,
  output logic sum,
  output logic carry
);
  assign sum   = in_x ^ in_y;
  assign carry = in_x & in_y;
endmodule

// File: rtl/bw_full_adder.sv
module bw_full_adder (
  input  logic in_x,
  input  logic in_y,
  input  logic in_c,
  output logic sum,
  output logic carry
);
  assign sum   = in_x ^ in_y ^ in_c;
  assign carry = (in_x & in_y) | (in_c & (in_x ^ in_y));
endmodule

// File: rtl/bw_pp_matrix.sv
module bw_pp_matrix
  import bw_mult_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic [WIDTH-1:0]            mcand,
  input  logic [WIDTH-1:0]            mplier,
  output logic [WIDTH-1:0][WIDTH-1:0] pp      // pp[row][col]
);
  for (genvar r = 0; r < WIDTH; r++) begin : g_row
    for (genvar c = 0; c < WIDTH; c++) begin : g_col
      if (pp_is_inverted(r, c, WIDTH, SIGNED_MODE)) begin : g_nand
        assign pp[r][c] = ~(mcand[c] & mplier[r]);
      end else begin : g_and
        assign pp[r][c] = mcand[c] & mplier[r];
      end
    end
  end
endmodule

// File: rtl/bw_adder_row.sv
module bw_adder_row #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] pp_in,    // partial-product row
  input  logic [WIDTH-1:0] acc_in,   // running sum, already shifted
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0] carry;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    if (k == 0) begin : g_ha
      bw_half_adder u_ha (
        .in_x (pp_in[k]),
        .in_y (acc_in[k]),
        .sum  (sum[k]),
        .carry(carry[k])
      );
    end else begin : g_fa
      bw_full_adder u_fa (
        .in_x (pp_in[k]),
        .in_y (acc_in[k]),
        .in_c (carry[k-1]),
        .sum  (sum[k]),
        .carry(carry[k])
      );
    end
  end

  assign cout = carry[WIDTH-1];

  // The row must compute an exact (WIDTH+1)-bit sum of its two inputs.
  always_comb begin
    AST_ROW_EXACT: assert ({cout, sum} == ({1'b0, pp_in} + {1'b0, acc_in})) // R1
      else $error("adder row sum mismatch");
  end
endmodule

// File: rtl/bw_array_mult.sv
module bw_array_mult #(
  parameter int WIDTH       = 8,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;
  localparam logic INJECT_ONE = SIGNED_MODE;

  logic [WIDTH-1:0][WIDTH-1:0] pp;
  logic [WIDTH-1:0]            acc_in   [1:WIDTH-1];
  logic [WIDTH-1:0]            row_sum  [1:WIDTH-1];
  logic                        row_cout [1:WIDTH-1];

  bw_pp_matrix #(.WIDTH(WIDTH), .SIGNED_MODE(SIGNED_MODE)) u_pp (
    .mcand (op_a),
    .mplier(op_b),
    .pp    (pp)
  );

  for (genvar r = 1; r < WIDTH; r++) begin : g_rows
    if (r == 1) begin : g_first
      // Row 0 passes its upper bits on; column WIDTH takes the injected one.
      assign acc_in[r] = {INJECT_ONE, pp[0][WIDTH-1:1]};
    end else begin : g_next
      assign acc_in[r] = {row_cout[r-1], row_sum[r-1][WIDTH-1:1]};
    end
    bw_adder_row #(.WIDTH(WIDTH)) u_row (
      .pp_in (pp[r]),
      .acc_in(acc_in[r]),
      .sum   (row_sum[r]),
      .cout  (row_cout[r])
    );
  end

  assign product[0] = pp[0][0];
  for (genvar r = 1; r < WIDTH - 1; r++) begin : g_low
    assign product[r] = row_sum[r][0];
  end
  assign product[PW-2:WIDTH-1] = row_sum[WIDTH-1];
  assign product[PW-1]         = row_cout[WIDTH-1] ^ INJECT_ONE;

  // Reference values for the checks below.
  logic [PW-1:0] ref_signed;
  logic [PW-1:0] ref_unsigned;
  assign ref_signed   = {{WIDTH{op_a[WIDTH-1]}}, op_a} * {{WIDTH{op_b[WIDTH-1]}}, op_b};
  assign ref_unsigned = {{WIDTH{1'b0}}, op_a} * {{WIDTH{1'b0}}, op_b};

  always_comb begin
    if (SIGNED_MODE) begin
      AST_SIGNED_EXACT: assert (product == ref_signed) // R1
        else $error("signed product mismatch");
      if (op_a != '0 && op_b != '0) begin
        AST_SIGN_BIT: assert (product[PW-1] == (op_a[WIDTH-1] ^ op_b[WIDTH-1])) // R4
          else $error("product sign bit wrong");
      end
    end else begin
      AST_UNSIGNED_EXACT: assert (product == ref_unsigned) // R5
        else $error("unsigned product mismatch");
    end
    AST_LOW_BIT: assert (product[0] == (op_a[0] & op_b[0])) // R3
      else $error("product bit 0 wrong");
    if (op_a == '0 || op_b == '0) begin
      AST_ZERO_OPERAND: assert (product == '0) // R7
        else $error("zero operand gave nonzero product");
    end
  end
endmodule

// File: tb/test_bw_array_mult.sv
module test_bw_array_mult;
  localparam int W4 = 4;
  localparam int W6 = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic [W4-1:0]   s4_a, s4_b, u4_a, u4_b;
  logic [2*W4-1:0] s4_p, u4_p;
  logic [W6-1:0]   s6_a, s6_b;
  logic [2*W6-1:0] s6_p;

  bw_array_mult #(.WIDTH(W4), .SIGNED_MODE(1'b1)) i_bw_array_mult (
    .op_a(s4_a), .op_b(s4_b), .product(s4_p));
  bw_array_mult #(.WIDTH(W4), .SIGNED_MODE(1'b0)) i_bw_array_mult_u4 (
    .op_a(u4_a), .op_b(u4_b), .product(u4_p));
  bw_array_mult #(.WIDTH(W6), .SIGNED_MODE(1'b1)) i_bw_array_mult_s6 (
    .op_a(s6_a), .op_b(s6_b), .product(s6_p));

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  function automatic longint sval(input int x, input int w);
    return (x >= (1 << (w - 1))) ? longint'(x) - (longint'(1) << w) : longint'(x);
  endfunction

  function automatic longint wrap(input longint v, input int w);
    return v & ((longint'(1) << w) - 1);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    s4_a = '0; s4_b = '0; u4_a = '0; u4_b = '0; s6_a = '0; s6_b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset zero s4", longint'(s4_p), 0);
    check("R7 reset zero u4", longint'(u4_p), 0);

    // Exhaustive 4-bit sweeps, signed and unsigned.
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        @(posedge clk);
        s4_a = W4'(x); s4_b = W4'(y); u4_a = W4'(x); u4_b = W4'(y);
        @(negedge clk);
        check("R1 signed w4", longint'(s4_p), wrap(sval(x, W4) * sval(y, W4), 2 * W4));
        check("R5 unsigned w4", longint'(u4_p), longint'(x * y));
        check("R3 bit0", longint'(s4_p[0]), longint'(x & y & 1));
        if (x != 0 && y != 0)
          check("R4 sign bit", longint'(s4_p[2*W4-1]), longint'(((x >> 3) ^ (y >> 3)) & 1));
        if (x == 0 || y == 0) begin
          check("R7 zero operand signed", longint'(s4_p), 0);
          check("R7 zero operand unsigned", longint'(u4_p), 0);
        end
        if (y == 15)
          check("R8 times minus one", longint'(s4_p), wrap(-sval(x, W4), 2 * W4));
      end
    end

    // Corner cases called out by name.
    @(posedge clk);
    s4_a = 4'h8; s4_b = 4'h8; u4_a = 4'hF; u4_b = 4'hF;
    @(negedge clk);
    check("R2 most negative squared", longint'(s4_p), 64'h40);
    check("R6 unsigned max squared", longint'(u4_p), 64'hE1);

    // Exhaustive 6-bit signed sweep.
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) begin
        @(posedge clk);
        s6_a = W6'(x); s6_b = W6'(y);
        @(negedge clk);
        check("R1 signed w6", longint'(s6_p), wrap(sval(x, W6) * sval(y, W6), 2 * W6));
      end
    end
    @(posedge clk);
    s6_a = 6'h20; s6_b = 6'h20;
    @(negedge clk);
    check("R2 most negative squared w6", longint'(s6_p), 64'h400);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule